// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's load/store port and a slower memory. It holds a small number of lines, each one block of several words together with a valid flag, a modified flag and the upper address bits of the block it holds. Each address can live in exactly one line, chosen by the block address modulo the line count. Every accepted request is registered first. The following cycle compares the stored tag against the request. A hit finishes in that compare cycle: a read returns its word, and a store writes its word and marks the line modified.

On a miss the processor is held off. If the chosen line holds modified data, that block is first sent to memory as a whole line. Only after memory acknowledges it is the wanted block fetched. The fetched block is installed clean and the request goes back through the compare step, where it now hits. Stores that miss therefore allocate: the block is fetched and the store word is merged into it on the retry. Memory may take any number of cycles to acknowledge a transfer.

Top module: `dc_wb_cache`

## Requirements
- R1: A synchronous active-low reset clears every line's valid flag and returns the controller to idle. While reset is asserted, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are low. After reset the first access to any address is a miss.
- R2: With the default geometry (16-bit word address, 4 words per line, 8 lines), bits [1:0] select the word, bits [4:2] select the line and bits [15:5] form the tag. `mem_addr` carries the block address (address bits [15:2]). In `mem_wdata` and `mem_rdata`, word w occupies bits [32*w+31 : 32*w].
- R3: A request is accepted in the cycle it is seen while the controller is idle. A hit needs a set valid flag and a matching tag, and it raises `cpu_ready` in the next cycle, with no memory request. The read data is valid in that same cycle. `cpu_ready` is high for one cycle per request and never without one.
- R4: A miss on a clean or invalid line raises `mem_rd_req` for the requested block. The returned line is installed with its tag and a set valid flag. `cpu_ready` rises in the cycle after `mem_ack`.
- R5: A store hit writes only the addressed word and marks the line modified. A store miss leaves the line unchanged until the refill; the store word is then merged into the fetched block and the other words keep their fetched values.
- R6: A miss on a valid modified line first raises `mem_wr_req` with the victim's block address and full line contents. `mem_rd_req` rises only in the cycle after the write is acknowledged.
- R7: A refill leaves the line unmodified, so evicting a line that was only read after its refill produces no write to memory.
- R8: `mem_rd_req` and `mem_wr_req` are never high together. Each request stays high, with a stable address, until the cycle in which `mem_ack` is sampled high.
- R9: Memory acknowledgement may come in the first request cycle or after any number of wait cycles. A clean miss completes 3+L cycles after the request is presented, and a dirty miss 4+2L cycles after, where L is the number of wait cycles per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | WORD_W | Store data |
| cpu_rdata | output | WORD_W | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes at this clock edge |
| mem_rd_req | output | 1 | Block fetch request |
| mem_wr_req | output | 1 | Block write-back request |
| mem_addr | output | ADDR_W-OFF_W | Block address of the transfer |
| mem_wdata | output | LINE_W | Line sent on write-back |
| mem_rdata | input | LINE_W | Line returned on fetch, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory completes the current transfer |

## Verification
The hardest case to reach is a miss whose victim is modified. It needs a store that hits, followed by an access to a different tag on the same line. Only that sequence makes the write-back precede the fetch, and only then do the written-back contents reappear on a later re-fetch. The stimulus table builds these pairs on purpose, including a store miss that evicts a dirty line. Each access is then checked for cycle count, for the number and order of memory transfers, and for the contents of every written-back line. A final pass repeats dirty evictions with zero and long memory delays, so that a wrong wait cycle in either transfer shows up in the latency.

// File: rtl/dc_pkg.sv
// Shared types for the write-back data cache.
package dc_pkg;
    // Controller phases: accept, tag check, victim write, block fetch.
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_COMPARE   = 2'd1,
        ST_WRITEBACK = 2'd2,
        ST_ALLOCATE  = 2'd3
    } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
// Per-line valid flag, modified flag and tag.
// Assumes a single line index shared by read and update, given by the controller.
// Valid and modified flags reset; tags do not (they are ignored while invalid).
module dc_tag_store #(
    parameter int LINES = 8,
    parameter int TAG_W = 11,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             set_dirty,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Flag update: reset clears, fill validates and cleans, store hit marks modified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (set_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag load on fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= fill_tag;
        end
    end

    // Lookup of the addressed line.
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
    end

    AST_RESET_CLEARS_VALID: assert property (@(posedge clk) !rst_n |=> (valid_q == '0)); // R1
    AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (valid_q[$past(idx)] && !dirty_q[$past(idx)])); // R7
    AST_FILL_NOT_WITH_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && set_dirty)); // R5
endmodule

// File: rtl/dc_data_store.sv
// Line data, one bank per word position so a store touches a single word
// while a refill writes all banks at once. Assumes word and line writes never coincide.
module dc_data_store #(
    parameter int LINES      = 8,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int LINE_W = LINE_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  word_sel,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_wdata,
    input  logic              line_we,
    input  logic [LINE_W-1:0] line_wdata,
    output logic [LINE_W-1:0] line_rdata
);
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_bank
        logic [WORD_W-1:0] bank_q [LINES];

        // Bank write: whole-line refill or single-word store.
        always_ff @(posedge clk) begin
            if (line_we) begin
                bank_q[idx] <= line_wdata[w*WORD_W +: WORD_W];
            end else if (word_we && (word_sel == OFF_W'(w))) begin
                bank_q[idx] <= word_wdata;
            end
        end

        assign line_rdata[w*WORD_W +: WORD_W] = bank_q[idx];
    end

    AST_ONE_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_we && line_we)); // R5
endmodule

// File: rtl/dc_ctrl.sv
// Miss handler and request sequencer. Registers each accepted request,
// checks the tag in the next cycle, writes back a modified victim, fetches
// the block, then re-runs the tag check. Assumes the requester holds its
// request stable until ready, and memory holds nothing between transfers.
module dc_ctrl
    import dc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 3,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
    localparam int BLK_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              line_valid,
    input  logic              line_dirty,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic              mem_ack,
    output logic [IDX_W-1:0]  req_idx,
    output logic [OFF_W-1:0]  req_off,
    output logic [TAG_W-1:0]  req_tag,
    output logic              fill_en,
    output logic              set_dirty,
    output logic              word_we,
    output logic [WORD_W-1:0] word_wdata,
    output logic              cpu_ready,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [BLK_W-1:0]  mem_blk_addr
);
    dc_state_e         state_q, state_d;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              hit;

    assign req_tag    = addr_q[ADDR_W-1 -: TAG_W];
    assign req_idx    = addr_q[OFF_W +: IDX_W];
    assign req_off    = addr_q[OFF_W-1:0];
    assign word_wdata = wdata_q;
    assign hit        = line_valid && (line_tag == req_tag);

    // Next phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:      if (cpu_req) state_d = ST_COMPARE;
            ST_COMPARE: begin
                if (hit)                          state_d = ST_IDLE;
                else if (line_valid && line_dirty) state_d = ST_WRITEBACK;
                else                              state_d = ST_ALLOCATE;
            end
            ST_WRITEBACK: if (mem_ack) state_d = ST_ALLOCATE;
            ST_ALLOCATE:  if (mem_ack) state_d = ST_COMPARE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && cpu_req) begin
            we_q    <= cpu_we;
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
        end
    end

    // Phase-decoded controls toward the stores, the processor and memory.
    always_comb begin
        cpu_ready    = (state_q == ST_COMPARE) && hit;
        word_we      = cpu_ready && we_q;
        set_dirty    = cpu_ready && we_q;
        fill_en      = (state_q == ST_ALLOCATE) && mem_ack;
        mem_wr_req   = (state_q == ST_WRITEBACK);
        mem_rd_req   = (state_q == ST_ALLOCATE);
        mem_blk_addr = (state_q == ST_WRITEBACK) ? {line_tag, req_idx} : {req_tag, req_idx};
    end

    AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_blk_addr))); // R8
    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_blk_addr))); // R8
    AST_FETCH_NOT_OVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALLOCATE && $past(state_q) == ST_COMPARE) |-> !$past(line_valid && line_dirty)); // R6
    AST_RETRY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> cpu_ready); // R4
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R3
endmodule

// File: rtl/dc_wb_cache.sv
// Direct-mapped write-back data cache top level: ties the controller to the
// tag and data stores and selects the read word. Assumes LINES and LINE_WORDS
// are powers of two and LINE_WORDS is at least 2.
module dc_wb_cache #(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 8,
    localparam int OFF_W  = $clog2(LINE_WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
    localparam int LINE_W = LINE_WORDS * WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    cpu_ready,
    output logic                    mem_rd_req,
    output logic                    mem_wr_req,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [LINE_W-1:0]       mem_wdata,
    input  logic [LINE_W-1:0]       mem_rdata,
    input  logic                    mem_ack
);
    logic [IDX_W-1:0]  req_idx;
    logic [OFF_W-1:0]  req_off;
    logic [TAG_W-1:0]  req_tag;
    logic              fill_en, set_dirty, word_we;
    logic [WORD_W-1:0] word_wdata;
    logic              line_valid, line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic [LINE_W-1:0] line_rdata;

    dc_ctrl #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag),
        .mem_ack(mem_ack),
        .req_idx(req_idx), .req_off(req_off), .req_tag(req_tag),
        .fill_en(fill_en), .set_dirty(set_dirty), .word_we(word_we), .word_wdata(word_wdata),
        .cpu_ready(cpu_ready), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
        .mem_blk_addr(mem_addr)
    );

    dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
        .clk(clk), .rst_n(rst_n), .idx(req_idx),
        .fill_en(fill_en), .fill_tag(req_tag), .set_dirty(set_dirty),
        .line_valid(line_valid), .line_dirty(line_dirty), .line_tag(line_tag)
    );

    dc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) data_i (
        .clk(clk), .rst_n(rst_n), .idx(req_idx),
        .word_sel(req_off), .word_we(word_we), .word_wdata(word_wdata),
        .line_we(fill_en), .line_wdata(mem_rdata), .line_rdata(line_rdata)
    );

    assign cpu_rdata = line_rdata[req_off*WORD_W +: WORD_W];
    assign mem_wdata = line_rdata;

    AST_MEM_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R8
    AST_READY_NO_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !(mem_rd_req || mem_wr_req)); // R3
endmodule

// File: tb/dc_wb_cache_tb.sv
`timescale 1ns/1ps
module dc_wb_cache_tb_top;
    localparam int AW = 16;
    localparam int WW = 32;
    localparam int NW = 4;
    localparam int LW = NW * WW;
    localparam int BW = AW - 2;
    localparam logic [1:0] K_HIT = 2'd0, K_CLEAN = 2'd1, K_DIRTY = 2'd2;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [1:0]  kind;
        logic [3:0]  rq;
    } vec_t;

    // addr = tag<<5 | line<<2 | word
    localparam vec_t VECS [16] = '{
        '{1'b0, 16'h0020, 32'h0,         K_CLEAN, 4'd1}, // first access after reset
        '{1'b0, 16'h0023, 32'h0,         K_HIT,   4'd3},
        '{1'b1, 16'h0021, 32'hA5A5_0001, K_HIT,   4'd5}, // R5 store hit
        '{1'b0, 16'h0021, 32'h0,         K_HIT,   4'd5},
        '{1'b0, 16'h0042, 32'h0,         K_DIRTY, 4'd6}, // R6 evict modified
        '{1'b0, 16'h0021, 32'h0,         K_CLEAN, 4'd7}, // R7 refilled line is clean
        '{1'b1, 16'h0066, 32'h1234_5678, K_CLEAN, 4'd5}, // store miss allocates
        '{1'b0, 16'h0064, 32'h0,         K_HIT,   4'd5},
        '{1'b0, 16'h0066, 32'h0,         K_HIT,   4'd5},
        '{1'b1, 16'h0084, 32'hDEAD_BEEF, K_DIRTY, 4'd6}, // store miss over dirty
        '{1'b0, 16'h0066, 32'h0,         K_DIRTY, 4'd6},
        '{1'b0, 16'h0084, 32'h0,         K_CLEAN, 4'd7},
        '{1'b0, 16'h00BF, 32'h0,         K_CLEAN, 4'd2}, // last line, last word
        '{1'b0, 16'h00BF, 32'h0,         K_HIT,   4'd2},
        '{1'b1, 16'hFFEB, 32'hFFFF_0000, K_CLEAN, 4'd2}, // all-ones tag
        '{1'b0, 16'h000B, 32'h0,         K_DIRTY, 4'd2}  // zero tag evicts it
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [WW-1:0] cpu_wdata, cpu_rdata;
    logic          cpu_ready, mem_rd_req, mem_wr_req, mem_ack;
    logic [BW-1:0] mem_addr;
    logic [LW-1:0] mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    dc_wb_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int checks = 0;
    int errors = 0;
    int lat = 2;
    int rd_cnt = 0, wr_cnt = 0, wr_at_rd = 0;
    logic [BW-1:0] last_rd_blk = '0;
    logic [WW-1:0] gold [int];
    logic [LW-1:0] mstore [int];

    function automatic logic [WW-1:0] pat(input logic [AW-1:0] a);
        return 32'hC300_0000 | ({16'd0, a} << 4) | {28'd0, a[3:0]};
    endfunction

    function automatic logic [WW-1:0] gold_word(input logic [AW-1:0] a);
        if (gold.exists(int'(a))) return gold[int'(a)];
        return pat(a);
    endfunction

    function automatic logic [LW-1:0] mem_line(input logic [BW-1:0] b);
        logic [LW-1:0] l;
        if (mstore.exists(int'(b))) return mstore[int'(b)];
        for (int w = 0; w < NW; w++) l[w*WW +: WW] = pat({b, 2'(w)});
        return l;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Memory model with configurable wait cycles; checks the handshake and written-back contents.
    initial begin
        int wait_cnt = 0;
        logic bad = 1'b0;
        logic pend = 1'b0;
        logic [BW-1:0] pend_addr = '0;
        logic [LW-1:0] exp_l;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_rd_req && mem_wr_req) bad = 1'b1;
            if (pend && !(mem_rd_req || mem_wr_req)) bad = 1'b1;
            if (pend && mem_addr !== pend_addr) bad = 1'b1;
            if (rst_n && (mem_rd_req || mem_wr_req)) begin
                if (wait_cnt >= lat) begin
                    mem_ack = 1'b1;
                    wait_cnt = 0;
                    pend = 1'b0;
                    chk("R8", {31'd0, bad}, 32'd0, "request held and exclusive");
                    bad = 1'b0;
                    if (mem_wr_req) begin
                        for (int w = 0; w < NW; w++) exp_l[w*WW +: WW] = gold_word({mem_addr, 2'(w)});
                        checks++;
                        if (mem_wdata !== exp_l) begin
                            errors++;
                            $display("FAIL R6 written-back line %h: actual %h expected %h", mem_addr, mem_wdata, exp_l);
                        end
                        mstore[int'(mem_addr)] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata = mem_line(mem_addr);
                        last_rd_blk = mem_addr;
                        wr_at_rd = wr_cnt;
                        rd_cnt++;
                    end
                end else begin
                    wait_cnt++;
                    pend = 1'b1;
                    pend_addr = mem_addr;
                end
            end
        end
    end

    // One processor access with latency, data and transfer-count checks.
    task automatic access(input logic we, input logic [AW-1:0] a, input logic [WW-1:0] d,
                          input logic [1:0] kind, input string rq);
        int cyc = 0;
        int rd0 = rd_cnt, wr0 = wr_cnt;
        int exp_cyc;
        logic [WW-1:0] got;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do begin
            @(negedge clk);
            cyc++;
        end while (!cpu_ready && cyc < 300);
        got = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        exp_cyc = (kind == K_HIT) ? 1 : (kind == K_CLEAN) ? 3 + lat : 4 + 2 * lat;
        chk(rq, cyc, exp_cyc, "cycles to ready");
        if (!we) chk(rq, got, gold_word(a), "read data");
        chk(rq, rd_cnt - rd0, (kind == K_HIT) ? 0 : 1, "block fetches");
        chk(rq, wr_cnt - wr0, (kind == K_DIRTY) ? 1 : 0, "block write-backs");
        if (kind != K_HIT) chk("R2", 32'(last_rd_blk), 32'(a[AW-1:2]), "fetched block address");
        if (kind == K_DIRTY) chk("R6", wr_at_rd - wr0, 1, "write-back before fetch");
        if (we) gold[int'(a)] = d;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1", {29'd0, cpu_ready, mem_rd_req, mem_wr_req}, 32'd0, "outputs in reset");
        rst_n = 1'b1;

        foreach (VECS[i])
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].kind, $sformatf("R%0d", VECS[i].rq));

        // R3: no request, no activity
        repeat (6) begin
            @(negedge clk);
            chk("R3", {30'd0, cpu_ready, mem_rd_req | mem_wr_req}, 32'd0, "idle outputs");
        end

        // R1: reset invalidates cached lines
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        access(1'b0, 16'h0020, 32'h0, K_CLEAN, "R1");

        // R9: immediate acknowledge
        lat = 0;
        access(1'b0, 16'h0024, 32'h0, K_CLEAN, "R9");
        access(1'b1, 16'h0025, 32'h0BAD_F00D, K_HIT, "R5");
        // R9: long wait on both transfers of a dirty miss
        lat = 7;
        access(1'b0, 16'h0044, 32'h0, K_DIRTY, "R9");
        access(1'b0, 16'h0025, 32'h0, K_CLEAN, "R9");
        // R4: clean miss with one wait cycle
        lat = 1;
        access(1'b0, 16'h1234, 32'h0, K_CLEAN, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule